// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block makes the priority decision for an eight-line interrupt controller. The surrounding logic latches requests and keeps the mask and in-service state. This block takes those vectors, together with a rotation base and three mode straps. It decides whether the processor should be interrupted and, if so, which line wins.

Priority rotates. The line at the rotation base ranks highest, and rank grows by one for each line after it, wrapping modulo 8. A pending, unmasked request raises an interrupt only when its rank is strictly better than every level already in service. Two modes can remove bits from the in-service set before that comparison:

- Special-mask mode removes masked lines from it.
- Nested-cascade mode, on the master unit only, removes the cascade line (line 2).

The decision and the winning line index are registered. They appear one clock after the inputs are applied.

Top module: `irq_prio_resolver`

## Requirements
- R1: While reset is asserted, and after it, until the first clock edge with reset released, `int_req` is 0 and `irq_idx` is 0.
- R2: The candidate set is `req_pend & ~req_mask`. When it is empty, `int_req` is 0, whatever the other inputs are.
- R3: Line i has rank (i − `rot_base`) mod 8, and rank 0 is the highest. The line at `rot_base` is top priority, and the winner is the candidate with the smallest rank.
- R4: An interrupt is raised only when the best candidate rank is strictly smaller than the best rank in the filtered in-service set. An empty in-service set counts as rank 8. A line that is in service blocks itself and every line of lower priority.
- R5: When `spec_mask_en` is 1, in-service bits of masked lines are left out of the comparison. When it is 0, they take part.
- R6: When `nest_en` is 1 and `is_master` is 1, in-service bit 2 is left out of the comparison. If either input is 0, bit 2 takes part like any other bit.
- R7: `irq_idx` is the winning line number, (winning rank + `rot_base`) mod 8, whenever `int_req` is 1. It is 0 whenever `int_req` is 0.
- R8: Both outputs are registered. They reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_pend | input | 8 | Latched pending requests, one bit per line |
| req_mask | input | 8 | Mask; a 1 blocks the line |
| in_svc | input | 8 | Lines currently in service |
| rot_base | input | 3 | Line holding the highest priority |
| spec_mask_en | input | 1 | Special-mask mode: leave masked lines out of in-service comparison |
| nest_en | input | 1 | Nested-cascade mode enable |
| is_master | input | 1 | Strap: 1 when this unit is the master |
| int_req | output | 1 | Interrupt request to the processor |
| irq_idx | output | 3 | Winning line number, 0 when idle |

## Verification
Both results come from one register stage. A vector applied before a rising edge is reflected on `int_req` and `irq_idx` right after that edge, and it is never visible in the same cycle. The bench drives every vector on a falling edge. At the next falling edge it compares both outputs with a behavioural loop model evaluated on the vector of the previous half-period, so each check lands exactly one edge after its stimulus. Directed vectors cover the rank, strict-comparison and filtering corner cases, and a long random run sweeps all eight base values.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N_LINES      = 8,
  parameter int CASCADE_LINE = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_LINES-1:0]         req_pend,
  input  logic [N_LINES-1:0]         req_mask,
  input  logic [N_LINES-1:0]         in_svc,
  input  logic [$clog2(N_LINES)-1:0] rot_base,
  input  logic                       spec_mask_en,
  input  logic                       nest_en,
  input  logic                       is_master,
  output logic                       int_req,
  output logic [$clog2(N_LINES)-1:0] irq_idx
);
  localparam int IDX_W  = $clog2(N_LINES);
  localparam int RANK_W = IDX_W + 1;

  function automatic logic [N_LINES-1:0] rot_right(input logic [N_LINES-1:0] v,
                                                   input logic [IDX_W-1:0] b);
    logic [N_LINES-1:0] r;
    for (int k = 0; k < N_LINES; k++) r[k] = v[(k + int'(b)) % N_LINES];
    return r;
  endfunction

  function automatic logic [RANK_W-1:0] first_rank(input logic [N_LINES-1:0] v);
    logic [RANK_W-1:0] r;
    r = RANK_W'(N_LINES);
    for (int k = N_LINES - 1; k >= 0; k--) if (v[k]) r = RANK_W'(k);
    return r;
  endfunction

  logic [N_LINES-1:0] cand, casc_drop, svc_filt;
  logic [RANK_W-1:0]  cand_rank, svc_rank;
  logic               raise;
  logic [IDX_W-1:0]   win_idx;

  assign cand      = req_pend & ~req_mask;
  assign casc_drop = (nest_en && is_master) ? (N_LINES'(1) << CASCADE_LINE) : '0;
  assign svc_filt  = in_svc & ~(spec_mask_en ? req_mask : '0) & ~casc_drop;
  assign cand_rank = first_rank(rot_right(cand, rot_base));
  assign svc_rank  = first_rank(rot_right(svc_filt, rot_base));
  assign raise     = cand_rank < svc_rank;
  assign win_idx   = cand_rank[IDX_W-1:0] + rot_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_req <= 1'b0;
      irq_idx <= '0;
    end else begin
      int_req <= raise;
      irq_idx <= raise ? win_idx : '0;
    end
  end

  AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !int_req |-> irq_idx == '0); // R7

  AST_NO_CAND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pend & ~req_mask) == '0 |=> !int_req); // R2

  AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((($past(req_pend & ~req_mask)) >> irq_idx) & N_LINES'(1)) != '0); // R2

  AST_BASE_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (((req_pend & ~req_mask) >> rot_base) & N_LINES'(1)) != '0 && in_svc == '0
    |=> int_req && irq_idx == $past(rot_base)); // R3

  AST_BASE_SVC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_svc >> rot_base) & N_LINES'(1)) != '0 && !spec_mask_en
    && !(nest_en && is_master && int'(rot_base) == CASCADE_LINE)
    |=> !int_req); // R4
endmodule

// File: tb/tb_irq_prio_resolver.sv
module tb_irq_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_pend = '0, req_mask = '0, in_svc = '0;
  logic [2:0] rot_base = '0;
  logic       spec_mask_en = 1'b0, nest_en = 1'b0, is_master = 1'b0;
  logic       int_req;
  logic [2:0] irq_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit exp_int;
  int exp_idx;

  always #4 clk = ~clk;

  irq_prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_mask(req_mask),
    .in_svc(in_svc), .rot_base(rot_base), .spec_mask_en(spec_mask_en),
    .nest_en(nest_en), .is_master(is_master), .int_req(int_req), .irq_idx(irq_idx)
  );

  function automatic void model(output bit ir, output int idx);
    int best_c = 8;
    int best_s = 8;
    for (int r = 7; r >= 0; r--) begin
      int line = (r + int'(rot_base)) % 8;
      bit c = req_pend[line] && !req_mask[line];
      bit s = in_svc[line];
      if (spec_mask_en && req_mask[line]) s = 0;
      if (nest_en && is_master && line == 2) s = 0;
      if (c) best_c = r;
      if (s) best_s = r;
    end
    ir  = (best_c < 8) && (best_c < best_s);
    idx = ir ? (best_c + int'(rot_base)) % 8 : 0;
  endfunction

  task automatic check(string tag, bit e_int, int e_idx);
    checks++;
    if (int_req !== e_int || int'(irq_idx) != e_idx || $isunknown(irq_idx)) begin
      errors++;
      $display("FAIL %s: got int_req=%0b irq_idx=%0d, expected int_req=%0b irq_idx=%0d",
               tag, int_req, irq_idx, e_int, e_idx);
    end
  endtask

  task automatic apply(input logic [7:0] p, m, s, input logic [2:0] b,
                       input logic sm, nf, ms);
    req_pend = p; req_mask = m; in_svc = s; rot_base = b;
    spec_mask_en = sm; nest_en = nf; is_master = ms;
    model(exp_int, exp_idx);
  endtask

  task automatic step(string tag, input logic [7:0] p, m, s, input logic [2:0] b,
                      input logic sm, nf, ms);
    apply(p, m, s, b, sm, nf, ms);
    @(negedge clk);
    check(tag, exp_int, exp_idx);
  endtask

  initial begin
    apply(8'hFF, 8'h00, 8'h00, 3'd3, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 during reset", 0, 0);
    rst_n = 1'b1;
    #1 check("R1 after release", 0, 0);
    @(negedge clk);
    check("R8 first edge", 1, 3);

    step("R2 all masked",        8'hFF, 8'hFF, 8'h00, 3'd0, 0, 0, 0);
    check("R7 idle index", 0, 0);
    step("R2 nothing pending",   8'h00, 8'h00, 8'h00, 3'd5, 0, 0, 0);
    step("R2 mask one of two",   8'h0A, 8'h02, 8'h00, 3'd0, 0, 0, 0);
    check("R7 index line3", 1, 3);
    step("R3 base0 lowest wins", 8'h90, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    step("R3 base5 wrap",        8'h11, 8'h00, 8'h00, 3'd5, 0, 0, 0);
    check("R3 base5 expect 0", 1, 0);
    step("R3 base at line",      8'h81, 8'h00, 8'h00, 3'd7, 0, 0, 0);
    check("R3 base7 expect 7", 1, 7);
    step("R4 equal rank blocks", 8'h10, 8'h00, 8'h10, 3'd0, 0, 0, 0);
    check("R4 equal rank", 0, 0);
    step("R4 higher wins",       8'h08, 8'h00, 8'h10, 3'd0, 0, 0, 0);
    check("R4 higher", 1, 3);
    step("R4 lower blocked",     8'h20, 8'h00, 8'h10, 3'd0, 0, 0, 0);
    check("R4 lower", 0, 0);
    step("R4 rotated compare",   8'h01, 8'h00, 8'h40, 3'd6, 0, 0, 0);
    check("R4 rotated", 0, 0);
    step("R5 off blocks",        8'h20, 8'h08, 8'h08, 3'd0, 0, 0, 0);
    check("R5 off", 0, 0);
    step("R5 on unblocks",       8'h20, 8'h08, 8'h08, 3'd0, 1, 0, 0);
    check("R5 on", 1, 5);
    step("R6 master nested",     8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 1);
    check("R6 master", 1, 3);
    step("R6 slave nested",      8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 0);
    check("R6 slave", 0, 0);
    step("R6 master not nested", 8'h08, 8'h00, 8'h04, 3'd0, 0, 0, 1);
    check("R6 off", 0, 0);
    step("R6 cascade self",      8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 1);
    check("R6 self", 1, 2);

    for (int n = 0; n < 4000; n++) begin
      step("R8 random", 8'($urandom), 8'($urandom), 8'($urandom & $urandom),
           3'(n % 8), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule